// File: doc/BRIEF.md
# Mask-Steered Bit Partition Unit

This unit splits an 8-bit data word into two groups under the control of an 8-bit steering mask that holds exactly four set bits. Data bits flagged by a set mask bit are collected into the upper half of the result. Data bits flagged by a clear mask bit are collected into the lower half. Within each group the bits keep the order they had in the input word.

Each result bit comes from a narrow five-way selector. The reason is that the k-th set bit counted from the top of a balanced mask can only occupy five neighbouring positions, and the same holds for the k-th clear bit counted from the bottom. A decode stage finds these positions in the mask and drives the selector controls. No lookup table and no full crossbar is used. A word is accepted when the input strobe is high and appears one clock later with its own strobe. A mask that is not balanced returns a zero word with the error flag set.

Top module: `bitpart_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, `resWord`, `resValid` and `maskErr` are all 0.
- R2: `resValid` is high in the cycle after a rising clock edge that sampled `inValid` high, and low in the cycle after an edge that sampled `inValid` low.
- R3: For a mask with exactly four ones, scanning the mask from bit 7 downward, the data bit at the first set mask bit appears on `resWord[7]`, the second on `resWord[6]`, the third on `resWord[5]` and the fourth on `resWord[4]`.
- R4: For a mask with exactly four ones, scanning the mask from bit 0 upward, the data bit at the first clear mask bit appears on `resWord[0]`, the second on `resWord[1]`, the third on `resWord[2]` and the fourth on `resWord[3]`.
- R5: A sampled mask with exactly four ones gives `maskErr` = 0 with its result.
- R6: A sampled mask with any other number of ones (0 to 3 or 5 to 8) gives `maskErr` = 1 and `resWord` = 8'h00 with its result.
- R7: An edge with `inValid` low leaves `resWord` and `maskErr` unchanged, whatever `dataIn` and `maskIn` carry.
- R8: For a balanced mask, the result has the same number of ones as the sampled data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe for dataIn and maskIn |
| dataIn | input | 8 | Data word to partition |
| maskIn | input | 8 | Steering mask, expected to hold four ones |
| resWord | output | 8 | Partitioned word, registered |
| resValid | output | 1 | One-cycle strobe marking a new result |
| maskErr | output | 1 | Set with a result whose mask was not balanced |

## Verification
If the decode picks the wrong rank for a set or clear bit, the wrong data bit reaches a result position. This shows on `resWord` in the very next cycle, as long as the two candidate data bits differ. Each balanced mask is therefore driven with several random data words, so a bad selector is exposed with high probability. A miscount of mask ones shows as a wrong `maskErr`, or as a nonzero word where zero is required, on the same result cycle. A broken hold path shows on the first idle cycle that follows a result.

// File: rtl/bitpart_pkg.sv
package bitpart_pkg;
  localparam int WORD_W = 8;
  localparam int HALF_W = WORD_W / 2;
  localparam int WIN_N  = WORD_W - HALF_W + 1;
  localparam int SEL_W  = $clog2(WIN_N);
  localparam int IDX_W  = $clog2(WORD_W);

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic                  load;
    logic                  maskOk;
    logic [HALF_W-1:0][SEL_W-1:0] selHi;
    logic [HALF_W-1:0][SEL_W-1:0] selLo;
  } strobe_t;
endpackage

// File: rtl/bitpart_ctrl.sv
module bitpart_ctrl
  import bitpart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] maskIn,
  output strobe_t           stb
);
  logic [HALF_W-1:0][IDX_W-1:0] hiPos;
  logic [HALF_W-1:0][IDX_W-1:0] loPos;
  int onesCnt;
  int zeroCnt;

  // Locate ranked ones scanning down and ranked zeros scanning up.
  always_comb begin
    onesCnt = 0;
    zeroCnt = 0;
    for (int k = 0; k < HALF_W; k++) begin
      hiPos[k] = IDX_W'(WORD_W - 1 - k);
      loPos[k] = IDX_W'(k);
    end
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (maskIn[i]) begin
        for (int k = 0; k < HALF_W; k++) begin
          if (onesCnt == k) hiPos[k] = IDX_W'(i);
        end
        onesCnt = onesCnt + 1;
      end
    end
    for (int i = 0; i < WORD_W; i++) begin
      if (!maskIn[i]) begin
        for (int k = 0; k < HALF_W; k++) begin
          if (zeroCnt == k) loPos[k] = IDX_W'(i);
        end
        zeroCnt = zeroCnt + 1;
      end
    end
  end

  always_comb begin
    stb.load   = inValid;
    stb.maskOk = (onesCnt == HALF_W);
    for (int k = 0; k < HALF_W; k++) begin
      if (stb.maskOk) begin
        stb.selHi[k] = SEL_W'(WORD_W - 1 - k - int'(hiPos[k]));
        stb.selLo[k] = SEL_W'(int'(loPos[k]) - k);
      end else begin
        stb.selHi[k] = '0;
        stb.selLo[k] = '0;
      end
    end
  end

  generate
    for (genvar g = 0; g < HALF_W; g++) begin : gChk
      AST_HI_SEL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        stb.maskOk |-> (int'(stb.selHi[g]) < WIN_N)); // R3
      AST_LO_SEL_WINDOW: assert property (@(posedge clk) disable iff (rst)
        stb.maskOk |-> (int'(stb.selLo[g]) < WIN_N)); // R4
      AST_HI_PICKS_ONE: assert property (@(posedge clk) disable iff (rst)
        stb.maskOk |-> maskIn[WORD_W - 1 - g - int'(stb.selHi[g])]); // R3
      AST_LO_PICKS_ZERO: assert property (@(posedge clk) disable iff (rst)
        stb.maskOk |-> !maskIn[g + int'(stb.selLo[g])]); // R4
    end
  endgenerate
endmodule

// File: rtl/bitpart_dp.sv
module bitpart_dp
  import bitpart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] resWord,
  output logic              resValid,
  output logic              maskErr
);
  logic [WORD_W-1:0] packedWord;

  generate
    for (genvar k = 0; k < HALF_W; k++) begin : gMux
      logic hiBit;
      logic loBit;
      always_comb begin
        hiBit = 1'b0;
        loBit = 1'b0;
        for (int j = 0; j < WIN_N; j++) begin
          if (stb.selHi[k] == SEL_W'(j)) hiBit = dataIn[WORD_W - 1 - k - j];
          if (stb.selLo[k] == SEL_W'(j)) loBit = dataIn[k + j];
        end
      end
      assign packedWord[WORD_W - 1 - k] = hiBit;
      assign packedWord[k]              = loBit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resWord  <= '0;
      resValid <= 1'b0;
      maskErr  <= 1'b0;
    end else begin
      resValid <= stb.load;
      if (stb.load) begin
        resWord <= stb.maskOk ? packedWord : '0;
        maskErr <= !stb.maskOk;
      end
    end
  end

  AST_LOAD_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> resValid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> !resValid); // R2
  AST_ERR_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
    (resValid && maskErr) |-> (resWord == '0)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> ($stable(resWord) && $stable(maskErr))); // R7
  AST_ONES_KEPT: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.maskOk) |=> ($countones(resWord) == $countones($past(dataIn)))); // R8
endmodule

// File: rtl/bitpart_top.sv
module bitpart_top
  import bitpart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] dataIn,
  input  logic [WORD_W-1:0] maskIn,
  output logic [WORD_W-1:0] resWord,
  output logic              resValid,
  output logic              maskErr
);
  strobe_t stb;

  bitpart_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .maskIn  (maskIn),
    .stb     (stb)
  );

  bitpart_dp uDp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .dataIn   (dataIn),
    .resWord  (resWord),
    .resValid (resValid),
    .maskErr  (maskErr)
  );
endmodule

// File: tb/tb_bitpart_top.sv
`timescale 1ns/1ps
module tb_bitpart_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] maskIn = '0;
  logic [7:0] resWord;
  logic       resValid;
  logic       maskErr;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] expWord = '0;
  logic       expValid = 1'b0;
  logic       expErr = 1'b0;
  logic       prevLoad = 1'b0;
  logic       prevGood = 1'b0;

  always #5 clk = ~clk;

  bitpart_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn), .maskIn(maskIn),
    .resWord(resWord), .resValid(resValid), .maskErr(maskErr)
  );

  function automatic logic [7:0] refPart(logic [7:0] d, logic [7:0] m);
    logic [7:0] r;
    bit ones[$];
    bit zeros[$];
    r = '0;
    for (int i = 7; i >= 0; i--) if (m[i]) ones.push_back(d[i]);
    for (int i = 0; i < 8; i++) if (!m[i]) zeros.push_back(d[i]);
    if (ones.size() != 4) return 8'h00;
    for (int k = 0; k < 4; k++) begin
      r[7 - k] = ones[k];
      r[k]     = zeros[k];
    end
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (mask %h data %h)", tag, act, exp, maskIn, dataIn);
    end
  endtask

  // Compare the outputs for the previous edge, then drive the next input set.
  task automatic step(logic v, logic [7:0] d, logic [7:0] m);
    @(negedge clk);
    chk("R2 valid", int'(resValid), int'(expValid));
    if (prevLoad && prevGood) begin
      chk("R3 R4 word", int'(resWord), int'(expWord));
      chk("R5 err", int'(maskErr), int'(expErr));
      chk("R8 ones", $countones(resWord), $countones(expWord));
    end else if (prevLoad) begin
      chk("R6 word", int'(resWord), int'(expWord));
      chk("R6 err", int'(maskErr), int'(expErr));
    end else begin
      chk("R7 word", int'(resWord), int'(expWord));
      chk("R7 err", int'(maskErr), int'(expErr));
    end
    inValid = v;
    dataIn  = d;
    maskIn  = m;
    prevLoad = v;
    prevGood = ($countones(m) == 4);
    expValid = v;
    if (v) begin
      expWord = refPart(d, m);
      expErr  = ($countones(m) != 4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 word", int'(resWord), 0);
    chk("R1 valid", int'(resValid), 0);
    chk("R1 err", int'(maskErr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 word after", int'(resWord), 0);
    chk("R1 valid after", int'(resValid), 0);
    // fixed corner patterns
    step(1'b1, 8'hF0, 8'hF0);
    step(1'b1, 8'hA5, 8'h0F);
    step(1'b1, 8'h96, 8'hAA);
    step(1'b1, 8'hFF, 8'h00);
    step(1'b1, 8'hFF, 8'hFF);
    step(1'b0, 8'h3C, 8'h0F);
    step(1'b0, 8'hC3, 8'h1F);
    // full sweep of masks
    for (int m = 0; m < 256; m++) begin
      int reps;
      reps = ($countones(m[7:0]) == 4) ? 3 : 1;
      for (int r = 0; r < reps; r++) begin
        step(1'b1, 8'($urandom), 8'(m));
      end
      if (m % 16 == 0) step(1'b0, 8'($urandom), 8'($urandom));
    end
    step(1'b0, 8'h00, 8'h00);
    step(1'b0, 8'hFF, 8'h55);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule